// File: doc/BRIEF.md
# Link Auto-Negotiation Arbiter

This block runs the arbitration half of auto-negotiation for a 10/100 twisted-pair link. It receives partner code words that a separate pulse decoder has already turned into a four-bit ability field and an acknowledge flag. It chooses the ability field and acknowledge flag to send back. It picks the best mode that both ends support. When the partner never sends code words, it falls back to parallel detection, where the speed is sensed from the line. Pulse encoding, the management bus and next-page exchange are handled elsewhere.

Control comes from plain configuration inputs: a restart request, a negotiation enable, a forced speed bit, a forced duplex bit and four advertised-ability bits. A restart silences all link-pulse activity for a break period set by a parameter and then starts again. A burst-timeout parameter sets how long the block waits for a partner word before it gives up on that phase. With the enable cleared the block skips negotiation and reports a link in the forced mode.

Ability fields on every port use one bit order: bit 3 is 100M full duplex, bit 2 is 100M half duplex, bit 1 is 10M full duplex and bit 0 is 10M half duplex. The resolved mode is the index of the chosen bit: 3 is 100M full, 2 is 100M half, 1 is 10M full and 0 is 10M half.

Top module: `anlink_arbiter`

## Requirements
- R1: During and just after reset, the block is in the ability phase. In this state flp_tx_en=1, tx_ack=0, link_good=0, lp_an_able=0 and pd_fault=0, and tx_abil holds the value cfg_adv had during reset.
- R2: tx_abil takes the value of cfg_adv only on a clock edge where cfg_restart=1 and cfg_an_en=1. A change to cfg_adv at any other time leaves tx_abil unchanged.
- R3: The mode is chosen from the AND of tx_abil and the partner ability field. The highest set bit wins, so the priority is 100M full duplex (mode 3), then 100M half (2), then 10M full (1), then 10M half (0). If the AND is zero, the block stays in the ability phase with tx_ack=0.
- R4: After a partner word with a common ability arrives, tx_ack=1. link_good rises with link_mode set to the resolved mode on the edge that samples the ACK_WORDS-th consecutive partner word that both has rx_ack=1 and matches the stored ability field. A matching word with rx_ack=0 resets this count.
- R5: In the acknowledge phase, a partner word whose ability field differs from the stored one sends the block back to the ability phase (tx_ack=0, flp_tx_en=1).
- R6: In the acknowledge phase, if no partner word arrives for more than BURST_TO cycles, the block goes back to the ability phase.
- R7: A restart request (cfg_restart=1 with cfg_an_en=1) takes priority over every other event except a cleared enable. It sets flp_tx_en=0 and link_good=0 on the next cycle and clears pd_fault. It keeps them that way for at least BREAK_CYC cycles, ignores partner words during that time, and then returns to the ability phase.
- R8: link_lost=1 in the acknowledge phase or with a negotiated link sends the block back to the ability phase. It wins over a partner word that would have completed the acknowledge in the same cycle.
- R9: If the ability phase times out with no partner word and exactly one of det_100_sym and det_10_nlp set, a half-duplex link forms at the detected speed (mode 2 or 0). lp_abil then shows the one-hot bit of that mode and lp_an_able=0.
- R10: If the ability phase times out with both detect inputs set, pd_fault goes to 1, no link forms and the block stays in the ability phase.
- R11: With cfg_an_en=0, link_good=1, link_mode={cfg_force_100, cfg_force_fd} and flp_tx_en=0, and restart requests have no effect. While cfg_an_en=1, the forced bits do not affect link_mode.
- R12: A partner word received in the ability phase loads lp_abil with its ability field and sets lp_an_able=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_restart | input | 1 | Restart request |
| cfg_an_en | input | 1 | Negotiation enable |
| cfg_force_100 | input | 1 | Forced speed, 1 = 100M |
| cfg_force_fd | input | 1 | Forced duplex, 1 = full |
| cfg_adv | input | 4 | Abilities to advertise |
| rx_word_valid | input | 1 | One-cycle strobe for a decoded partner word |
| rx_abil | input | 4 | Partner ability field |
| rx_ack | input | 1 | Partner acknowledge flag |
| det_100_sym | input | 1 | 100M symbols sensed on the line |
| det_10_nlp | input | 1 | 10M link pulses sensed on the line |
| link_lost | input | 1 | Signal loss on the line |
| flp_tx_en | output | 1 | Link-pulse bursts are being sent |
| tx_abil | output | 4 | Ability field being sent |
| tx_ack | output | 1 | Acknowledge flag being sent |
| link_good | output | 1 | Link is up |
| link_mode | output | 2 | Resolved or forced mode |
| lp_abil | output | 4 | Partner abilities, received or detected |
| lp_an_able | output | 1 | Partner negotiates (expansion bit 0) |
| pd_fault | output | 1 | Parallel-detection fault (expansion bit 4) |

## Verification
The two events that can land on the same clock edge are loss of signal and the final acknowledged partner word that would otherwise bring the link up. The bench sets up this collision on purpose: it holds link_lost high during the strobe of the third acknowledged word. It then checks that link_good stays low and that the block is sending link pulses again without the acknowledge flag. In a second collision, a restart request arrives in the same cycle as a partner word. The bench checks that the word is dropped, which shows up as lp_abil keeping its old value, and that pulse transmission stops.

// File: rtl/anlink_pkg.sv
// Shared types for the link auto-negotiation arbiter.
// Assumes the four-bit ability order used on all ports: 3=100FD, 2=100HD, 1=10FD, 0=10HD.
package anlink_pkg;
    localparam int unsigned ABIL_W = 4;
    localparam int unsigned MODE_W = 2;

    typedef enum logic [2:0] {
        ST_BREAK,
        ST_ABIL,
        ST_ACK,
        ST_LINK,
        ST_FORCED
    } an_state_e;
endpackage

// File: rtl/anlink_resolve.sv
// Priority resolver: returns the index of the highest set bit of the common
// ability vector. Assumes bit order equals mode priority (highest index wins).
module anlink_resolve #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0]         common,
    output logic                 found,
    output logic [$clog2(N)-1:0] idx
);
    localparam int unsigned IW = $clog2(N);

    // Scan upward so the last (highest) set bit overrides lower ones.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < int'(N); i++) begin
            if (common[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/anlink_timer.sv
// Down-counting interval timer. It reloads on load and reports expired when it
// reaches zero. Assumes the owner reloads it on every event that restarts the window.
module anlink_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    // Load, else count down towards zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= load_val;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/anlink_arbiter.sv
// Link auto-negotiation arbiter for a 10/100 link. It sequences the break, ability,
// acknowledge and link phases, resolves the common mode, falls back to
// parallel detection, and supports a forced mode. Assumes decoded partner
// words arrive as one-cycle strobes and that all inputs are synchronous to clk.
module anlink_arbiter
    import anlink_pkg::*;
#(
    parameter int unsigned BREAK_CYC = 31_250_000,
    parameter int unsigned BURST_TO  = 1_250_000,
    parameter int unsigned ACK_WORDS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_restart,
    input  logic              cfg_an_en,
    input  logic              cfg_force_100,
    input  logic              cfg_force_fd,
    input  logic [ABIL_W-1:0] cfg_adv,
    input  logic              rx_word_valid,
    input  logic [ABIL_W-1:0] rx_abil,
    input  logic              rx_ack,
    input  logic              det_100_sym,
    input  logic              det_10_nlp,
    input  logic              link_lost,
    output logic              flp_tx_en,
    output logic [ABIL_W-1:0] tx_abil,
    output logic              tx_ack,
    output logic              link_good,
    output logic [MODE_W-1:0] link_mode,
    output logic [ABIL_W-1:0] lp_abil,
    output logic              lp_an_able,
    output logic              pd_fault
);
    localparam int unsigned BRK_W = $clog2(BREAK_CYC + 1);
    localparam int unsigned BST_W = $clog2(BURST_TO + 1);
    localparam int unsigned CNT_W = $clog2(ACK_WORDS + 1);
    localparam logic [CNT_W-1:0] ACK_LAST = CNT_W'(ACK_WORDS - 1);

    an_state_e         state, state_nxt;
    logic [ABIL_W-1:0] adv_q, lp_q, lp_nxt;
    logic [MODE_W-1:0] mode_q, mode_nxt;
    logic [CNT_W-1:0]  ack_cnt, ack_cnt_nxt;
    logic              able_q, able_nxt, fault_q, fault_nxt;
    logic              go_restart, brk_expired, bst_expired, bst_load, in_flp;
    logic              rx_found, hold_found;
    logic [MODE_W-1:0] rx_idx, hold_idx;

    assign go_restart = cfg_an_en & cfg_restart;
    assign in_flp     = (state == ST_ABIL) || (state == ST_ACK);

    anlink_resolve #(.N(ABIL_W)) u_res_rx (
        .common (adv_q & rx_abil),
        .found  (rx_found),
        .idx    (rx_idx)
    );

    anlink_resolve #(.N(ABIL_W)) u_res_hold (
        .common (adv_q & lp_q),
        .found  (hold_found),
        .idx    (hold_idx)
    );

    anlink_timer #(.W(BRK_W)) u_brk_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (go_restart),
        .load_val (BRK_W'(BREAK_CYC)),
        .expired  (brk_expired)
    );

    assign bst_load = rx_word_valid | bst_expired | !in_flp | (state_nxt != state);

    anlink_timer #(.W(BST_W)) u_bst_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (bst_load),
        .load_val (BST_W'(BURST_TO)),
        .expired  (bst_expired)
    );

    // Next-state and status update; priority is disable, restart, then phase events.
    always_comb begin
        state_nxt   = state;
        lp_nxt      = lp_q;
        mode_nxt    = mode_q;
        ack_cnt_nxt = ack_cnt;
        able_nxt    = able_q;
        fault_nxt   = fault_q;
        if (!cfg_an_en) begin
            state_nxt = ST_FORCED;
        end else if (cfg_restart) begin
            state_nxt = ST_BREAK;
            fault_nxt = 1'b0;
        end else begin
            unique case (state)
                ST_FORCED: state_nxt = ST_ABIL;
                ST_BREAK:  if (brk_expired) state_nxt = ST_ABIL;
                ST_ABIL: begin
                    if (rx_word_valid) begin
                        lp_nxt   = rx_abil;
                        able_nxt = 1'b1;
                        if (rx_found) begin
                            state_nxt   = ST_ACK;
                            ack_cnt_nxt = '0;
                        end
                    end else if (bst_expired) begin
                        if (det_100_sym && det_10_nlp) begin
                            fault_nxt = 1'b1;
                        end else if (det_100_sym || det_10_nlp) begin
                            state_nxt = ST_LINK;
                            mode_nxt  = det_100_sym ? 2'd2 : 2'd0;
                            lp_nxt    = det_100_sym ? 4'b0100 : 4'b0001;
                            able_nxt  = 1'b0;
                        end
                    end
                end
                ST_ACK: begin
                    if (link_lost) begin
                        state_nxt = ST_ABIL;
                    end else if (rx_word_valid) begin
                        if (rx_abil != lp_q) begin
                            state_nxt = ST_ABIL;
                        end else if (!rx_ack) begin
                            ack_cnt_nxt = '0;
                        end else if (ack_cnt == ACK_LAST && hold_found) begin
                            state_nxt = ST_LINK;
                            mode_nxt  = hold_idx;
                        end else begin
                            ack_cnt_nxt = ack_cnt + 1'b1;
                        end
                    end else if (bst_expired) begin
                        state_nxt = ST_ABIL;
                    end
                end
                ST_LINK:  if (link_lost) state_nxt = ST_ABIL;
                default:  state_nxt = ST_ABIL;
            endcase
        end
    end

    // State and status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_ABIL;
            adv_q   <= cfg_adv;
            lp_q    <= '0;
            mode_q  <= '0;
            ack_cnt <= '0;
            able_q  <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            state   <= state_nxt;
            lp_q    <= lp_nxt;
            mode_q  <= mode_nxt;
            ack_cnt <= ack_cnt_nxt;
            able_q  <= able_nxt;
            fault_q <= fault_nxt;
            if (go_restart) adv_q <= cfg_adv;
        end
    end

    // Output decode from the phase.
    always_comb begin
        flp_tx_en  = in_flp;
        tx_abil    = adv_q;
        tx_ack     = (state == ST_ACK);
        link_good  = (state == ST_LINK) || (state == ST_FORCED);
        link_mode  = (state == ST_FORCED) ? {cfg_force_100, cfg_force_fd}
                   : (state == ST_LINK)   ? mode_q : '0;
        lp_abil    = lp_q;
        lp_an_able = able_q;
        pd_fault   = fault_q;
    end
endmodule

// File: rtl/anlink_arbiter_chk.sv
// Port-level property checker for anlink_arbiter, attached by bind.
// Assumes the port encodings stated in the block brief.
module anlink_arbiter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_restart,
    input logic       cfg_an_en,
    input logic       rx_word_valid,
    input logic       rx_ack,
    input logic       link_lost,
    input logic       flp_tx_en,
    input logic [3:0] tx_abil,
    input logic       link_good,
    input logic [1:0] link_mode,
    input logic       lp_an_able,
    input logic       pd_fault
);
    // R2: advertisement only moves on a restart request.
    p_adv_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_restart |=> $stable(tx_abil));

    // R4: a negotiated link only rises on an acknowledged partner word.
    p_link_on_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(link_good) && lp_an_able && $past(cfg_an_en)) |-> $past(rx_word_valid && rx_ack));

    // R7: a restart silences pulses and drops the link on the next cycle.
    p_break_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_restart && cfg_an_en) |=> (!flp_tx_en && !link_good && !pd_fault));

    // R8: signal loss with negotiation enabled drops the link.
    p_loss_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (link_lost && cfg_an_en) |=> !link_good);

    // R9: a link formed without partner words is half duplex.
    p_pd_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (link_good && cfg_an_en && $past(cfg_an_en) && !lp_an_able) |-> !link_mode[0]);

    // R10: a detection fault never coincides with a link.
    p_fault_nolink_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_fault) |-> !link_good);

    // R11: a cleared enable yields a forced link with no pulses.
    p_forced_up_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_an_en |=> (link_good && !flp_tx_en));
endmodule

bind anlink_arbiter anlink_arbiter_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_restart   (cfg_restart),
    .cfg_an_en     (cfg_an_en),
    .rx_word_valid (rx_word_valid),
    .rx_ack        (rx_ack),
    .link_lost     (link_lost),
    .flp_tx_en     (flp_tx_en),
    .tx_abil       (tx_abil),
    .link_good     (link_good),
    .link_mode     (link_mode),
    .lp_an_able    (lp_an_able),
    .pd_fault      (pd_fault)
);

// File: tb/anlink_arbiter_bench.sv
// Self-checking bench: a vector table of advertised/partner abilities, then
// directed tests for reset, timeouts, parallel detection, forcing and collisions.
module anlink_arbiter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BRK  = 20;
    localparam int BST  = 40;
    localparam int NACK = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_restart = 1'b0, cfg_an_en = 1'b1;
    logic       cfg_force_100 = 1'b0, cfg_force_fd = 1'b0;
    logic [3:0] cfg_adv = 4'b1011;
    logic       rx_word_valid = 1'b0, rx_ack = 1'b0;
    logic [3:0] rx_abil = '0;
    logic       det_100_sym = 1'b0, det_10_nlp = 1'b0, link_lost = 1'b0;
    logic       flp_tx_en, tx_ack, link_good, lp_an_able, pd_fault;
    logic [3:0] tx_abil, lp_abil;
    logic [1:0] link_mode;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    // {adv, partner, found, mode}
    localparam logic [10:0] VEC [0:7] = '{
        {4'b1111, 4'b1111, 1'b1, 2'd3},
        {4'b1111, 4'b0110, 1'b1, 2'd2},
        {4'b0111, 4'b1111, 1'b1, 2'd2},
        {4'b1111, 4'b0011, 1'b1, 2'd1},
        {4'b0101, 4'b0011, 1'b1, 2'd0},
        {4'b1010, 4'b0101, 1'b0, 2'd0},
        {4'b1001, 4'b1000, 1'b1, 2'd3},
        {4'b0011, 4'b1110, 1'b1, 2'd1}
    };

    anlink_arbiter #(.BREAK_CYC(BRK), .BURST_TO(BST), .ACK_WORDS(NACK)) u_anlink_arbiter (
        .clk(clk), .rst_n(rst_n), .cfg_restart(cfg_restart), .cfg_an_en(cfg_an_en),
        .cfg_force_100(cfg_force_100), .cfg_force_fd(cfg_force_fd), .cfg_adv(cfg_adv),
        .rx_word_valid(rx_word_valid), .rx_abil(rx_abil), .rx_ack(rx_ack),
        .det_100_sym(det_100_sym), .det_10_nlp(det_10_nlp), .link_lost(link_lost),
        .flp_tx_en(flp_tx_en), .tx_abil(tx_abil), .tx_ack(tx_ack), .link_good(link_good),
        .link_mode(link_mode), .lp_abil(lp_abil), .lp_an_able(lp_an_able), .pd_fault(pd_fault)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_word(input logic [3:0] ab, input logic ak);
        @(negedge clk);
        rx_word_valid = 1'b1; rx_abil = ab; rx_ack = ak;
        @(negedge clk);
        rx_word_valid = 1'b0; rx_ack = 1'b0;
        tick(2);
    endtask

    task automatic do_restart(input logic [3:0] adv);
        @(negedge clk);
        cfg_adv = adv; cfg_restart = 1'b1;
        @(negedge clk);
        cfg_restart = 1'b0;
        tick(BRK + 3);
    endtask

    initial begin
        logic [3:0] va, vl;
        tick(4);
        rst_n = 1'b1;
        tick(1);
        // R1: reset state
        chk("R1 flp_tx_en", flp_tx_en, 1);
        chk("R1 tx_ack", tx_ack, 0);
        chk("R1 link_good", link_good, 0);
        chk("R1 lp_an_able", lp_an_able, 0);
        chk("R1 pd_fault", pd_fault, 0);
        chk("R1 tx_abil", tx_abil, 4'b1011);

        // R2: advertisement change without restart is not taken
        cfg_adv = 4'b0001;
        tick(3);
        chk("R2 adv held", tx_abil, 4'b1011);

        // Vector table: R3 resolution, R4 acknowledge, R12 partner capture
        for (int i = 0; i < 8; i++) begin
            va = VEC[i][10:7];
            vl = VEC[i][6:3];
            do_restart(va);
            chk("R2 adv latched", tx_abil, va);
            send_word(vl, 1'b0);
            chk("R12 lp_abil", lp_abil, vl);
            chk("R12 lp_an_able", lp_an_able, 1);
            if (VEC[i][2]) begin
                chk("R4 tx_ack", tx_ack, 1);
                for (int k = 0; k < NACK; k++) send_word(vl, 1'b1);
                chk("R4 link_good", link_good, 1);
                chk("R3 link_mode", link_mode, VEC[i][1:0]);
            end else begin
                chk("R3 no common ack", tx_ack, 0);
                chk("R3 no common link", link_good, 0);
            end
        end

        // R11: forced bits ignored while enabled (link is up at mode 1)
        cfg_force_100 = 1'b1; cfg_force_fd = 1'b0;
        tick(2);
        chk("R11 force ignored", link_mode, 1);

        // R4: a non-ack matching word resets the consecutive count
        do_restart(4'b1111);
        send_word(4'b1100, 1'b0);
        send_word(4'b1100, 1'b1);
        send_word(4'b1100, 1'b1);
        send_word(4'b1100, 1'b0);
        send_word(4'b1100, 1'b1);
        send_word(4'b1100, 1'b1);
        chk("R4 count reset", link_good, 0);
        send_word(4'b1100, 1'b1);
        chk("R4 link after reset count", link_good, 1);
        chk("R4 mode", link_mode, 3);

        // R8: loss of signal drops the link
        @(negedge clk); link_lost = 1'b1;
        @(negedge clk); link_lost = 1'b0;
        chk("R8 link dropped", link_good, 0);
        chk("R8 pulses resume", flp_tx_en, 1);

        // R5: ability change during acknowledge
        send_word(4'b0011, 1'b0);
        chk("R5 in ack", tx_ack, 1);
        send_word(4'b0111, 1'b1);
        chk("R5 back to ability", tx_ack, 0);
        chk("R5 pulses", flp_tx_en, 1);

        // R6: burst timeout during acknowledge
        send_word(4'b0011, 1'b0);
        tick(BST + 5);
        chk("R6 timeout", tx_ack, 0);
        chk("R6 no link", link_good, 0);

        // R8 collision: loss in the same cycle as the completing word
        send_word(4'b0010, 1'b0);
        send_word(4'b0010, 1'b1);
        send_word(4'b0010, 1'b1);
        @(negedge clk);
        rx_word_valid = 1'b1; rx_abil = 4'b0010; rx_ack = 1'b1; link_lost = 1'b1;
        @(negedge clk);
        rx_word_valid = 1'b0; rx_ack = 1'b0; link_lost = 1'b0;
        chk("R8 collision link", link_good, 0);
        chk("R8 collision ack", tx_ack, 0);
        chk("R8 collision flp", flp_tx_en, 1);

        // R7 collision: restart in the same cycle as a partner word
        @(negedge clk);
        cfg_restart = 1'b1; rx_word_valid = 1'b1; rx_abil = 4'b1000;
        @(negedge clk);
        cfg_restart = 1'b0; rx_word_valid = 1'b0;
        chk("R7 restart silences", flp_tx_en, 0);
        chk("R7 word dropped", lp_abil, 4'b0010);
        tick(BRK - 4);
        chk("R7 still in break", flp_tx_en, 0);
        send_word(4'b0100, 1'b0);
        chk("R7 break ignores words", lp_abil, 4'b0010);
        tick(6);
        chk("R7 break over", flp_tx_en, 1);

        // R9: parallel detection at 100M
        det_100_sym = 1'b1;
        do_restart(4'b1111);
        tick(BST + 5);
        chk("R9 pd link", link_good, 1);
        chk("R9 pd mode", link_mode, 2);
        chk("R9 pd lp_abil", lp_abil, 4'b0100);
        chk("R9 pd lp_an_able", lp_an_able, 0);

        // R9: parallel detection at 10M
        det_100_sym = 1'b0; det_10_nlp = 1'b1;
        do_restart(4'b1111);
        tick(BST + 5);
        chk("R9 pd10 mode", link_mode, 0);
        chk("R9 pd10 lp_abil", lp_abil, 4'b0001);

        // R10: both detected is a fault; restart clears it (R7)
        det_100_sym = 1'b1;
        do_restart(4'b1111);
        tick(BST + 5);
        chk("R10 fault", pd_fault, 1);
        chk("R10 no link", link_good, 0);
        det_100_sym = 1'b0; det_10_nlp = 1'b0;
        do_restart(4'b1111);
        chk("R7 fault cleared", pd_fault, 0);

        // R11: forced mode
        @(negedge clk); cfg_an_en = 1'b0; cfg_force_100 = 1'b1; cfg_force_fd = 1'b0;
        tick(2);
        chk("R11 forced link", link_good, 1);
        chk("R11 forced mode", link_mode, 2);
        chk("R11 forced no pulses", flp_tx_en, 0);
        @(negedge clk); cfg_restart = 1'b1;
        @(negedge clk); cfg_restart = 1'b0;
        chk("R11 restart ignored", link_good, 1);
        cfg_force_100 = 1'b0; cfg_force_fd = 1'b1;
        tick(1);
        chk("R11 forced mode 10FD", link_mode, 1);
        @(negedge clk); cfg_an_en = 1'b1;
        tick(2);
        chk("R11 re-enable", flp_tx_en, 1);
        chk("R11 re-enable link", link_good, 0);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        end
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        end
        $finish;
    end
endmodule